// File: doc/BRIEF.md
# Interrupt Link Allocator

This block hands out interrupt links to device functions as they are brought up. There are eight links. Each allocation request names the slot and interrupt pin of the function. The block picks one link and returns it as a number from 1 to 8. Normally it picks the link that has been given out the fewest times. With the fixed-mapping input set, it instead derives the link from the slot and pin with a simple rotation.

If the chosen link is still unrouted, the block then picks a legacy IRQ line for it. It takes the least-used IRQ that has not been excluded and issues a single write of that IRQ number into the link's routing register. The link registers live outside the block and are presented to it as a flat input vector.

Before the first allocation, configuration commands can shape the IRQ table. A reserve command takes an IRQ out of the pool. A use command raises an IRQ's count so that later allocations avoid it. Once allocation has started, both commands are refused and the refusal is signalled.

Top module: `irq_link_alloc`

## Requirements
- R1: After reset, busy, done, wr_en, err_no_irq and cmd_reject are low and link_num is 0. Every link count is 0. An IRQ count is 0 when its bit in ALLOWED_IRQS (default 16'hDEF8: IRQs 3-7, 9-12, 14, 15) is set, and holds the excluded marker 8'hFF otherwise.
- R2: With fixed_map low, the link with the smallest count is chosen, and ties go to the lowest index. link_num reports the index plus one.
- R3: With fixed_map high, the link index is (4 + alloc_slot + alloc_pin) mod 8.
- R4: Every allocation increments the count of the chosen link, whichever mode chose it.
- R5: An IRQ is assigned only when the chosen link's register byte equals exactly 8'h80. When it is assigned, wr_en pulses together with done, wr_link holds the link index, and wr_irq holds the IRQ number zero-extended to 8 bits. Any other register value, including 8'h85, produces no write.
- R6: The assigned IRQ is the one with the smallest count that is not 8'hFF, ties going to the lowest number. Its count is then incremented.
- R7: While no allocation has yet been accepted, cmd_valid with cmd_reserve=1 sets the IRQ count of cmd_irq to 8'hFF. cmd_valid with cmd_reserve=0 increments that count unless it is 8'hFF.
- R8: From the first accepted allocation onward, commands change no count. Each refused command raises cmd_reject for the cycle after it.
- R9: When the chosen link needs an IRQ and every IRQ count is 8'hFF, no write is issued and err_no_irq pulses together with done.
- R10: Link and IRQ counts saturate at 8'hFE, so they never reach the excluded marker.
- R11: A request is accepted only while busy is low. busy stays high from the accepting edge until done. done rises 9 edges after acceptance in least-used mode and 1 edge after in fixed mode, and 17 edges later still when an IRQ search is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Allocation request, sampled while idle |
| alloc_slot | input | SLOT_W | Slot number of the requesting function |
| alloc_pin | input | PIN_W | Interrupt pin number of the requesting function |
| fixed_map | input | 1 | Choose the link by rotation instead of by least use |
| cmd_valid | input | 1 | Configuration command strobe |
| cmd_reserve | input | 1 | 1 = reserve the IRQ, 0 = count one use of it |
| cmd_irq | input | IRQ_W | IRQ number the command applies to |
| link_regs | input | NUM_LINKS*8 | Current link routing registers, link i in bits [8i+7:8i] |
| busy | output | 1 | An allocation is in progress |
| done | output | 1 | One-cycle pulse: allocation result valid |
| link_num | output | LINK_W+1 | Chosen link, index plus one |
| wr_en | output | 1 | Write of the chosen IRQ into a link register |
| wr_link | output | LINK_W | Link index to write |
| wr_irq | output | 8 | IRQ number to write |
| err_no_irq | output | 1 | Pulse with done: no IRQ was available |
| cmd_reject | output | 1 | Pulse: the previous cycle's command was refused |

## Verification
Each result has a fixed latency, counted in edges from the edge that accepts the request:

| Mode | IRQ search needed | done rises after |
|---|---|---|
| fixed-mapping | no | 1 edge |
| fixed-mapping | yes | 18 edges |
| least-used | no | 9 edges |
| least-used | yes | 26 edges |

The bench counts the edges up to done and compares that count with the expected value. It reads link_num, wr_en, wr_link, wr_irq and err_no_irq at the falling edge after the edge that raised done. A refused command is checked one cycle after it is driven, by looking for cmd_reject. The effect of a refused command, or of a saturated count, is checked through a later allocation whose IRQ choice would differ if that count had changed.

// File: rtl/irq_link_alloc_pkg.sv
// Package: shared constants and types for the interrupt link allocator.
// Assumes 8-bit use counts, where 8'hFF marks an excluded entry.
package irq_link_alloc_pkg;

    localparam int           CNT_W     = 8;
    localparam logic [7:0]   CNT_EXCL  = 8'hFF;
    localparam logic [7:0]   CNT_SAT   = 8'hFE;
    localparam logic [7:0]   LINK_OFF  = 8'h80;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LSCAN = 2'd1,
        ST_LDEC  = 2'd2,
        ST_ISCAN = 2'd3
    } alloc_state_e;

endpackage

// File: rtl/ila_count_bank.sv
// Module: a bank of saturating use counters with one combinational read port.
// Each entry resets to 0 if its ELIG_MASK bit is set, and to the excluded
// marker otherwise. Reserve overrides increment. An increment stops at the
// saturation value, so an excluded entry is never incremented.
module ila_count_bank #(
    parameter int                DEPTH     = 16,
    parameter int                IDX_W     = 4,
    parameter logic [DEPTH-1:0]  ELIG_MASK = '1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [IDX_W-1:0]                       rd_idx,
    output logic [irq_link_alloc_pkg::CNT_W-1:0]   rd_cnt,
    input  logic                                   inc_en,
    input  logic [IDX_W-1:0]                       inc_idx,
    input  logic                                   rsv_en,
    input  logic [IDX_W-1:0]                       rsv_idx
);
    import irq_link_alloc_pkg::*;

    logic [CNT_W-1:0] cnt_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
            // Purpose: reset, reserve or saturating-increment one entry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q[g] <= ELIG_MASK[g] ? '0 : CNT_EXCL;
                end else if (rsv_en && rsv_idx == MY_IDX) begin
                    cnt_q[g] <= CNT_EXCL;
                end else if (inc_en && inc_idx == MY_IDX && cnt_q[g] < CNT_SAT) begin
                    cnt_q[g] <= cnt_q[g] + 1'b1;
                end
            end
        end
    endgenerate

    // Purpose: combinational read of the entry under scan.
    always_comb begin
        rd_cnt = cnt_q[rd_idx];
    end

endmodule

// File: rtl/ila_min_scan.sv
// Module: a sequential minimum search, one entry per clock.
// A start pulse clears the result and points at entry 0. Entries 0 to
// DEPTH-1 are then compared on the following DEPTH edges. fin pulses on the
// edge that compares the last entry. A strictly smaller count replaces the
// best, so ties keep the lowest index. With SKIP_EXCL set, entries holding
// the excluded marker are never taken.
module ila_min_scan #(
    parameter int DEPTH     = 8,
    parameter int IDX_W     = 3,
    parameter bit SKIP_EXCL = 1'b0
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    output logic [IDX_W-1:0]                      rd_idx,
    input  logic [irq_link_alloc_pkg::CNT_W-1:0]  rd_cnt,
    output logic                                  fin,
    output logic                                  found,
    output logic [IDX_W-1:0]                      best_idx
);
    import irq_link_alloc_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic             active_q;
    logic [CNT_W-1:0] best_cnt_q;
    logic             take;

    // Purpose: decide whether the current entry beats the best so far.
    always_comb begin
        take = (!SKIP_EXCL || rd_cnt != CNT_EXCL) && (!found || rd_cnt < best_cnt_q);
    end

    // Purpose: step the index and keep the running minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            rd_idx     <= '0;
            fin        <= 1'b0;
            found      <= 1'b0;
            best_idx   <= '0;
            best_cnt_q <= '0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                rd_idx   <= '0;
                found    <= 1'b0;
            end else if (active_q) begin
                if (take) begin
                    found      <= 1'b1;
                    best_idx   <= rd_idx;
                    best_cnt_q <= rd_cnt;
                end
                if (rd_idx == LAST_IDX) begin
                    active_q <= 1'b0;
                    fin      <= 1'b1;
                end else begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ila_ctrl.sv
// Module: allocation sequencer.
// In idle it accepts a request and either starts the link search or
// computes the rotated link directly. It then makes the link decision, which
// bumps the link count and, if the link register is exactly 8'h80, starts
// the IRQ search. Finally it reports the result for one cycle. It also
// tracks the "no allocation yet" state that gates configuration commands.
// Assumes the link register bytes do not change while busy.
module ila_ctrl #(
    parameter int NUM_LINKS  = 8,
    parameter int LINK_W     = 3,
    parameter int IRQ_W      = 4,
    parameter int SLOT_W     = 5,
    parameter int PIN_W      = 3,
    parameter int FIXED_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  logic [PIN_W-1:0]  alloc_pin,
    input  logic              fixed_map,
    input  logic              cmd_valid,
    input  logic              link_fin,
    input  logic              link_found,
    input  logic [LINK_W-1:0] link_best,
    input  logic              irq_fin,
    input  logic              irq_found,
    input  logic [IRQ_W-1:0]  irq_best,
    input  logic [7:0]        chosen_reg,
    output logic              link_start,
    output logic              irq_start,
    output logic              link_inc,
    output logic [LINK_W-1:0] cur_link,
    output logic              irq_inc,
    output logic              cold,
    output logic              busy,
    output logic              done,
    output logic [LINK_W:0]   link_num,
    output logic              wr_en,
    output logic [LINK_W-1:0] wr_link,
    output logic [7:0]        wr_irq,
    output logic              err_no_irq,
    output logic              cmd_reject
);
    import irq_link_alloc_pkg::*;

    localparam int SUM_W = ((SLOT_W > PIN_W) ? SLOT_W : PIN_W) + 4;

    alloc_state_e      state_q;
    logic [LINK_W-1:0] sel_link_q;
    logic [SUM_W-1:0]  fix_sum;
    logic [LINK_W-1:0] fix_link;
    logic              accept;
    logic              decide;
    logic              irq_done;

    // Purpose: rotated link index for the fixed-mapping mode.
    always_comb begin
        fix_sum  = SUM_W'(FIXED_BASE) + SUM_W'(alloc_slot) + SUM_W'(alloc_pin);
        fix_link = LINK_W'(fix_sum % SUM_W'(NUM_LINKS));
    end

    // Purpose: per-cycle strobes to the scanners and counter banks.
    always_comb begin
        accept     = (state_q == ST_IDLE) && alloc_req;
        decide     = ((state_q == ST_LSCAN) && link_fin && link_found) || (state_q == ST_LDEC);
        cur_link   = (state_q == ST_LSCAN) ? link_best : sel_link_q;
        link_start = accept && !fixed_map;
        link_inc   = decide;
        irq_start  = decide && (chosen_reg == LINK_OFF);
        irq_done   = (state_q == ST_ISCAN) && irq_fin;
        irq_inc    = irq_done && irq_found;
    end

    // Purpose: state sequencing and registered result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sel_link_q <= '0;
            cold       <= 1'b1;
            busy       <= 1'b0;
            done       <= 1'b0;
            link_num   <= '0;
            wr_en      <= 1'b0;
            wr_link    <= '0;
            wr_irq     <= '0;
            err_no_irq <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            done       <= 1'b0;
            wr_en      <= 1'b0;
            err_no_irq <= 1'b0;
            cmd_reject <= cmd_valid && !cold;
            if (accept) begin
                cold <= 1'b0;
                busy <= 1'b1;
                if (fixed_map) begin
                    sel_link_q <= fix_link;
                    state_q    <= ST_LDEC;
                end else begin
                    state_q <= ST_LSCAN;
                end
            end else if (decide) begin
                sel_link_q <= cur_link;
                if (chosen_reg == LINK_OFF) begin
                    state_q <= ST_ISCAN;
                end else begin
                    done     <= 1'b1;
                    busy     <= 1'b0;
                    link_num <= (LINK_W + 1)'(cur_link) + (LINK_W + 1)'(1);
                    state_q  <= ST_IDLE;
                end
            end else if (irq_done) begin
                done       <= 1'b1;
                busy       <= 1'b0;
                link_num   <= (LINK_W + 1)'(sel_link_q) + (LINK_W + 1)'(1);
                wr_en      <= irq_found;
                wr_link    <= sel_link_q;
                wr_irq     <= 8'(irq_best);
                err_no_irq <= !irq_found;
                state_q    <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/irq_link_alloc.sv
// Module: top of the interrupt link allocator.
// Ties the sequencer to a link count bank, an IRQ count bank and one min
// scanner for each. Configuration commands reach the IRQ bank only while no
// allocation has been accepted. Assumes ALLOWED_IRQS has one bit per IRQ.
module irq_link_alloc #(
    parameter int                  NUM_LINKS    = 8,
    parameter int                  NUM_IRQS     = 16,
    parameter int                  SLOT_W       = 5,
    parameter int                  PIN_W        = 3,
    parameter int                  FIXED_BASE   = 4,
    parameter logic [NUM_IRQS-1:0] ALLOWED_IRQS = 16'hDEF8,
    localparam int                 LINK_W       = $clog2(NUM_LINKS),
    localparam int                 IRQ_W        = $clog2(NUM_IRQS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_req,
    input  logic [SLOT_W-1:0]      alloc_slot,
    input  logic [PIN_W-1:0]       alloc_pin,
    input  logic                   fixed_map,
    input  logic                   cmd_valid,
    input  logic                   cmd_reserve,
    input  logic [IRQ_W-1:0]       cmd_irq,
    input  logic [NUM_LINKS*8-1:0] link_regs,
    output logic                   busy,
    output logic                   done,
    output logic [LINK_W:0]        link_num,
    output logic                   wr_en,
    output logic [LINK_W-1:0]      wr_link,
    output logic [7:0]             wr_irq,
    output logic                   err_no_irq,
    output logic                   cmd_reject
);
    import irq_link_alloc_pkg::*;

    logic              link_start, link_fin, link_found, link_inc;
    logic [LINK_W-1:0] link_rd_idx, link_best, cur_link;
    logic [CNT_W-1:0]  link_rd_cnt;
    logic              irq_start, irq_fin, irq_found, irq_inc_ctrl;
    logic [IRQ_W-1:0]  irq_rd_idx, irq_best, irq_inc_idx;
    logic [CNT_W-1:0]  irq_rd_cnt;
    logic              cold;
    logic              cmd_rsv_en, irq_inc_en;
    logic [7:0]        chosen_reg;

    // Purpose: route commands and allocation bumps into the IRQ bank.
    always_comb begin
        cmd_rsv_en  = cmd_valid && cmd_reserve && cold;
        irq_inc_en  = irq_inc_ctrl || (cmd_valid && !cmd_reserve && cold);
        irq_inc_idx = irq_inc_ctrl ? irq_best : cmd_irq;
        chosen_reg  = link_regs[cur_link*8 +: 8];
    end

    ila_count_bank #(
        .DEPTH     (NUM_LINKS),
        .IDX_W     (LINK_W),
        .ELIG_MASK ({NUM_LINKS{1'b1}})
    ) u_link_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (link_rd_idx),
        .rd_cnt  (link_rd_cnt),
        .inc_en  (link_inc),
        .inc_idx (cur_link),
        .rsv_en  (1'b0),
        .rsv_idx ({LINK_W{1'b0}})
    );

    ila_count_bank #(
        .DEPTH     (NUM_IRQS),
        .IDX_W     (IRQ_W),
        .ELIG_MASK (ALLOWED_IRQS)
    ) u_irq_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (irq_rd_idx),
        .rd_cnt  (irq_rd_cnt),
        .inc_en  (irq_inc_en),
        .inc_idx (irq_inc_idx),
        .rsv_en  (cmd_rsv_en),
        .rsv_idx (cmd_irq)
    );

    ila_min_scan #(
        .DEPTH     (NUM_LINKS),
        .IDX_W     (LINK_W),
        .SKIP_EXCL (1'b0)
    ) u_link_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (link_start),
        .rd_idx   (link_rd_idx),
        .rd_cnt   (link_rd_cnt),
        .fin      (link_fin),
        .found    (link_found),
        .best_idx (link_best)
    );

    ila_min_scan #(
        .DEPTH     (NUM_IRQS),
        .IDX_W     (IRQ_W),
        .SKIP_EXCL (1'b1)
    ) u_irq_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (irq_start),
        .rd_idx   (irq_rd_idx),
        .rd_cnt   (irq_rd_cnt),
        .fin      (irq_fin),
        .found    (irq_found),
        .best_idx (irq_best)
    );

    ila_ctrl #(
        .NUM_LINKS  (NUM_LINKS),
        .LINK_W     (LINK_W),
        .IRQ_W      (IRQ_W),
        .SLOT_W     (SLOT_W),
        .PIN_W      (PIN_W),
        .FIXED_BASE (FIXED_BASE)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_req),
        .alloc_slot (alloc_slot),
        .alloc_pin  (alloc_pin),
        .fixed_map  (fixed_map),
        .cmd_valid  (cmd_valid),
        .link_fin   (link_fin),
        .link_found (link_found),
        .link_best  (link_best),
        .irq_fin    (irq_fin),
        .irq_found  (irq_found),
        .irq_best   (irq_best),
        .chosen_reg (chosen_reg),
        .link_start (link_start),
        .irq_start  (irq_start),
        .link_inc   (link_inc),
        .cur_link   (cur_link),
        .irq_inc    (irq_inc_ctrl),
        .cold       (cold),
        .busy       (busy),
        .done       (done),
        .link_num   (link_num),
        .wr_en      (wr_en),
        .wr_link    (wr_link),
        .wr_irq     (wr_irq),
        .err_no_irq (err_no_irq),
        .cmd_reject (cmd_reject)
    );

endmodule

// File: rtl/irq_link_alloc_sva.sv
// Module: protocol checker for the allocator's ports, bound to the top.
// Assumes the synchronous active-low reset of the top.
module ila_checker #(
    parameter int                  NUM_LINKS    = 8,
    parameter int                  NUM_IRQS     = 16,
    parameter int                  LINK_W       = 3,
    parameter logic [NUM_IRQS-1:0] ALLOWED_IRQS = 16'hDEF8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              cmd_valid,
    input logic              busy,
    input logic              done,
    input logic [LINK_W:0]   link_num,
    input logic              wr_en,
    input logic [7:0]        wr_irq,
    input logic              err_no_irq,
    input logic              cmd_reject
);

    a_r2_link_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (link_num != '0 && int'(link_num) <= NUM_LINKS));

    a_r5_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);

    a_r6_irq_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_irq) < NUM_IRQS && ALLOWED_IRQS[wr_irq[$clog2(NUM_IRQS)-1:0]]));

    a_r8_reject_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> $past(cmd_valid));

    a_r9_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_irq |-> (done && !wr_en));

    a_r11_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(alloc_req));

    a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind irq_link_alloc ila_checker #(
    .NUM_LINKS    (NUM_LINKS),
    .NUM_IRQS     (NUM_IRQS),
    .LINK_W       (LINK_W),
    .ALLOWED_IRQS (ALLOWED_IRQS)
) u_ila_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_req),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .done       (done),
    .link_num   (link_num),
    .wr_en      (wr_en),
    .wr_irq     (wr_irq),
    .err_no_irq (err_no_irq),
    .cmd_reject (cmd_reject)
);

// File: tb/tb_irq_link_alloc.sv
module tb_irq_link_alloc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [4:0]  alloc_slot = '0;
    logic [2:0]  alloc_pin = '0;
    logic        fixed_map = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_reserve = 1'b0;
    logic [3:0]  cmd_irq = '0;
    logic [63:0] link_regs;
    logic        busy, done, wr_en, err_no_irq, cmd_reject;
    logic [3:0]  link_num;
    logic [2:0]  wr_link;
    logic [7:0]  wr_irq;

    logic [7:0]  lreg [8];
    int          n_checks = 0;
    int          n_errors = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) link_regs[i*8 +: 8] = lreg[i];
    end

    irq_link_alloc dut (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_slot(alloc_slot),
        .alloc_pin(alloc_pin), .fixed_map(fixed_map), .cmd_valid(cmd_valid),
        .cmd_reserve(cmd_reserve), .cmd_irq(cmd_irq), .link_regs(link_regs),
        .busy(busy), .done(done), .link_num(link_num), .wr_en(wr_en),
        .wr_link(wr_link), .wr_irq(wr_irq), .err_no_irq(err_no_irq),
        .cmd_reject(cmd_reject)
    );

    // Vector fields: {fixed, slot[4:0], pin[2:0], link_num[3:0], wr, irq[7:0]}
    localparam int NVEC = 13;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 5'd0,  3'd0, 4'd1, 1'b1, 8'd6},
        {1'b0, 5'd0,  3'd0, 4'd2, 1'b1, 8'd7},
        {1'b0, 5'd0,  3'd0, 4'd3, 1'b1, 8'd9},
        {1'b0, 5'd0,  3'd0, 4'd4, 1'b1, 8'd10},
        {1'b0, 5'd0,  3'd0, 4'd5, 1'b1, 8'd11},
        {1'b0, 5'd0,  3'd0, 4'd6, 1'b1, 8'd12},
        {1'b0, 5'd0,  3'd0, 4'd7, 1'b1, 8'd14},
        {1'b0, 5'd0,  3'd0, 4'd8, 1'b1, 8'd6},
        {1'b0, 5'd0,  3'd0, 4'd1, 1'b0, 8'd0},
        {1'b1, 5'd3,  3'd1, 4'd1, 1'b0, 8'd0},
        {1'b1, 5'd2,  3'd3, 4'd2, 1'b0, 8'd0},
        {1'b0, 5'd0,  3'd0, 4'd3, 1'b0, 8'd0},
        {1'b1, 5'd31, 3'd4, 4'd8, 1'b0, 8'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alloc_req = 1'b0;
        cmd_valid = 1'b0;
        for (int i = 0; i < 8; i++) lreg[i] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_cmd(input logic rsv, input logic [3:0] irq, input int times);
        cmd_valid = 1'b1;
        cmd_reserve = rsv;
        cmd_irq = irq;
        repeat (times) @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_alloc(input logic f, input logic [4:0] s, input logic [2:0] p,
                            output int lat, output int ln, output int w,
                            output int irq, output int e);
        fixed_map = f;
        alloc_slot = s;
        alloc_pin = p;
        alloc_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        alloc_req = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        ln = int'(link_num);
        w = int'(wr_en);
        irq = int'(wr_irq);
        e = int'(err_no_irq);
        if (wr_en) lreg[wr_link] = wr_irq;
        if (!done) chk("R11 allocation timeout", 0, 1);
        else if (wr_en) chk("R5 write link index", int'(wr_link), ln - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lat, ln, w, irq, e;
        do_reset();
        // R1: reset state at the ports
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 link_num", int'(link_num), 0);
        chk("R1 wr_en", int'(wr_en), 0);
        chk("R1 err", int'(err_no_irq), 0);
        chk("R1 cmd_reject", int'(cmd_reject), 0);

        // R7: pre-allocation configuration
        do_cmd(1'b1, 4'd3, 1);
        chk("R7 no reject before allocation", int'(cmd_reject), 0);
        do_cmd(1'b0, 4'd4, 2);
        do_cmd(1'b0, 4'd15, 1);
        do_cmd(1'b1, 4'd5, 1);
        do_cmd(1'b0, 4'd8, 1);

        // R2 R3 R4 R5 R6 R11: vector table
        for (int k = 0; k < NVEC; k++) begin
            logic [21:0] v;
            int exp_lat;
            v = VEC[k];
            exp_lat = (v[21] ? 1 : 9) + (v[8] ? 17 : 0);
            do_alloc(v[21], v[20:16], v[15:13], lat, ln, w, irq, e);
            chk(v[21] ? "R3 fixed link" : "R2 least-used link", ln, int'(v[12:9]));
            chk("R5 write issued", w, int'(v[8]));
            if (v[8]) chk("R6 chosen irq", irq, int'(v[7:0]));
            chk("R9 no error", e, 0);
            chk("R11 latency", lat, exp_lat);
        end

        // R8: reserve after allocation is refused and flagged
        do_cmd(1'b1, 4'd7, 1);
        chk("R8 reject reserve", int'(cmd_reject), 1);
        do_cmd(1'b0, 4'd9, 1);
        chk("R8 reject use", int'(cmd_reject), 1);
        @(negedge clk);
        chk("R8 reject is a pulse", int'(cmd_reject), 0);
        // R8 R3 R4: disabled link 3 gets irq 7 (9 if the refused reserve had landed)
        lreg[3] = 8'h80;
        do_alloc(1'b1, 5'd6, 3'd1, lat, ln, w, irq, e);
        chk("R3 fixed link", ln, 4);
        chk("R8 refused reserve had no effect", irq, 7);
        chk("R11 fixed latency with irq", lat, 18);
        // R5: disable bit with a stale irq is not exactly 8'h80
        lreg[4] = 8'h85;
        do_alloc(1'b1, 5'd0, 3'd0, lat, ln, w, irq, e);
        chk("R5 link", ln, 5);
        chk("R5 no write for 8'h85", w, 0);

        // R1: counts restored by reset
        do_reset();
        do_alloc(1'b0, 5'd0, 3'd0, lat, ln, w, irq, e);
        chk("R1 link after reset", ln, 1);
        chk("R1 lowest allowed irq", irq, 3);
        chk("R11 least-used latency with irq", lat, 26);

        // R9: every allowed irq reserved
        do_reset();
        for (int q = 0; q < 16; q++) begin
            if ((16'hDEF8 >> q) & 1) do_cmd(1'b1, 4'(q), 1);
        end
        do_alloc(1'b0, 5'd0, 3'd0, lat, ln, w, irq, e);
        chk("R9 link", ln, 1);
        chk("R9 no write", w, 0);
        chk("R9 error pulse", e, 1);
        chk("R9 latency", lat, 26);

        // R10: saturation at 8'hFE
        do_reset();
        for (int q = 5; q < 16; q++) begin
            if ((16'hDEF8 >> q) & 1) do_cmd(1'b1, 4'(q), 1);
        end
        do_cmd(1'b0, 4'd3, 300);
        do_cmd(1'b0, 4'd4, 253);
        do_alloc(1'b0, 5'd0, 3'd0, lat, ln, w, irq, e);
        chk("R10 irq3 held at FE, irq4 at FD wins", irq, 4);
        do_alloc(1'b0, 5'd0, 3'd0, lat, ln, w, irq, e);
        chk("R10 tie at FE goes to lowest", irq, 3);
        do_alloc(1'b0, 5'd0, 3'd0, lat, ln, w, irq, e);
        chk("R10 irq3 not pushed to marker", irq, 3);
        chk("R10 write issued", w, 1);

        finish_run();
    end

endmodule